// File: doc/BRIEF.md
# Three-Lane TMDS Deskew Buffer

This block removes the channel-to-channel skew between three 10-bit TMDS character streams. The streams must already be word-aligned and in one clock domain. Each lane feeds a small circular buffer. A lane keeps overwriting buffer address 0 until it sees its alignment marker, which is the first non-control character after a run of control characters. From that clock on, its write pointer advances by one every cycle. When all three lanes have stored their marker at address 0, one shared read pointer starts at address 0 and reads every buffer together. The markers, and everything after them, then leave the block on the same clock.

The controller has two states. **ST_HUNT** searches for markers. **ST_LOCKED** streams aligned data. Four transitions connect them:
- **lock** (ST_HUNT to ST_LOCKED) fires when every lane has a marker.
- **span overflow** (ST_HUNT to ST_HUNT, with all lane pointers cleared) fires when the first marker is 15 clocks old and some lane still has none.
- **slip** (ST_LOCKED to ST_HUNT, with the lanes cleared) fires when a later control-to-data edge on the output shows up on some lanes but not all of them in the same cycle.
- **resync** (any state to ST_HUNT) clears everything.

While the block is not locked, every output lane carries the idle control code.

Top module: `tmds_lane_deskew`

## Requirements
- R1: A character counts as control when it equals one of 1101010100, 0010101011, 0101010100 or 1010101011. Any of the four may form a lane's control period.
- R2: A lane's marker is the first character that is not control and that directly follows a control character on that lane. Lanes are packed with lane i at bits [10*i+9:10*i].
- R3: Until its marker arrives, a lane writes every character to buffer address 0.
- R4: From its marker on, a lane writes to successive buffer addresses, one per clock, wrapping modulo the depth (16).
- R5: `aligned` rises on the clock edge that stores the last lane's marker. One clock later all lanes present their markers together, followed by each lane's later characters in order.
- R6: A marker spread of up to 15 clocks between the earliest and latest lane is aligned without error.
- R7: If 15 clocks pass after the first marker without all lanes marked, `align_err` and `overflow` are set and every lane returns to searching.
- R8: While aligned, a control-to-data edge on the output that appears on some lanes but not all in one cycle sets `align_err` (not `overflow`), clears `aligned` and restarts the search. Edges on all lanes together change nothing.
- R9: A synchronous `resync` high for one clock clears `aligned`, `align_err`, `overflow` and all pointers. The outputs show the idle code from the next clock on.
- R10: After reset, and whenever not aligned, every output lane carries 1101010100 and all status outputs are low.
- R11: `align_err` and `overflow` stay set until `resync` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resync | input | 1 | Synchronous clear and restart, active high |
| lanes_in | input | 30 | Word-aligned input characters, lane i at [10*i+9:10*i] |
| lanes_out | output | 30 | Deskewed output characters, same packing |
| aligned | output | 1 | All lanes locked and data being read |
| align_err | output | 1 | Sticky: marker spread too large or lock slipped |
| overflow | output | 1 | Sticky: marker spread exceeded buffer depth |

## Verification
Each lane is fed the same control-then-data burst shifted by its own delay. The tests use no skew, mixed skews, the largest legal spread of 15 and an illegal spread of 16. Together they separate correct address-0 parking from an off-by-one in the write pointer, in the read start or in the spread limit. Runs that use each of the four control codes show that detection does not hinge on one pattern. A second burst repeated in step checks that a correct lock survives. The same burst with one lane late by one clock must be reported as a slip. Resync applied while in error and while locked must return the outputs to idle on the next clock.

// File: rtl/tmds_deskew_pkg.sv
package tmds_deskew_pkg;

    localparam int SYM_W = 10;

    // control characters; IDLE is the code sent for control bits 00
    localparam logic [SYM_W-1:0] CODE_IDLE = 10'b1101010100;
    localparam logic [SYM_W-1:0] CODE_C01  = 10'b0010101011;
    localparam logic [SYM_W-1:0] CODE_C10  = 10'b0101010100;
    localparam logic [SYM_W-1:0] CODE_C11  = 10'b1010101011;

    typedef enum logic {
        ST_HUNT,
        ST_LOCKED
    } dsk_state_t;

    function automatic logic is_ctl_char(input logic [SYM_W-1:0] c);
        return (c == CODE_IDLE) || (c == CODE_C01) ||
               (c == CODE_C10)  || (c == CODE_C11);
    endfunction

endpackage

// File: rtl/deskew_lane.sv
module deskew_lane
    import tmds_deskew_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SYM_W-1:0] in_char,
    input  logic [AW-1:0]    rd_addr,
    output logic             found_o,
    output logic             marker_o,
    output logic [SYM_W-1:0] rd_char
);

    logic             prev_ctl_q;
    logic             found_q;
    logic [AW-1:0]    wptr_q;
    logic [AW-1:0]    waddr;
    logic             in_ctl;
    logic [SYM_W-1:0] buf_mem [DEPTH];

    assign in_ctl   = is_ctl_char(in_char);
    assign marker_o = !found_q && prev_ctl_q && !in_ctl;
    assign found_o  = found_q;
    assign waddr    = found_q ? wptr_q : '0;
    assign rd_char  = buf_mem[rd_addr];

    always_ff @(posedge clk) begin
        buf_mem[waddr] <= in_char;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ctl_q <= 1'b0;
            found_q    <= 1'b0;
            wptr_q     <= '0;
        end else begin
            prev_ctl_q <= in_ctl;
            if (clr) begin
                found_q <= 1'b0;
                wptr_q  <= '0;
            end else if (marker_o) begin
                found_q <= 1'b1;
                wptr_q  <= AW'(1);
            end else if (found_q) begin
                wptr_q  <= wptr_q + 1'b1;
            end
        end
    end

    AST_PARK_ADDR0: assert property (@(posedge clk) disable iff (!rst_n)
        !found_q |-> (wptr_q == '0)); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (found_q && !clr) |=> (wptr_q == AW'($past(wptr_q) + 1'b1))); // R4

endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import tmds_deskew_pkg::*;
#(
    parameter int LANES = 3,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resync,
    input  logic [LANES-1:0] found,
    input  logic [LANES-1:0] marker,
    input  logic [LANES-1:0] out_edge,
    output logic             clr_lanes,
    output logic [AW-1:0]    rd_addr,
    output logic             locked,
    output logic             align_err,
    output logic             overflow
);

    dsk_state_t    state_q, state_d;
    logic [AW-1:0] span_q;
    logic [AW-1:0] rptr_q;
    logic          all_now, any_q, span_hit, slip;

    assign all_now   = &(found | marker);
    assign any_q     = |found;
    assign span_hit  = (state_q == ST_HUNT) && any_q && !all_now &&
                       (span_q == AW'(DEPTH - 1));
    assign slip      = (state_q == ST_LOCKED) && (|out_edge) && !(&out_edge);
    assign clr_lanes = resync || span_hit || slip;

    always_comb begin
        state_d = state_q;
        if (resync) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT:   if (all_now) state_d = ST_LOCKED;
                ST_LOCKED: if (slip)    state_d = ST_HUNT;
                default:                state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q    <= '0;
            rptr_q    <= '0;
            align_err <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (clr_lanes || state_q == ST_LOCKED) span_q <= '0;
            else if (!any_q)                       span_q <= AW'(1);
            else                                   span_q <= span_q + 1'b1;

            if (state_q == ST_LOCKED && state_d == ST_LOCKED) rptr_q <= rptr_q + 1'b1;
            else                                              rptr_q <= '0;

            if (resync) begin
                align_err <= 1'b0;
                overflow  <= 1'b0;
            end else begin
                if (span_hit || slip) align_err <= 1'b1;
                if (span_hit)         overflow  <= 1'b1;
            end
        end
    end

    assign rd_addr = rptr_q;
    assign locked  = (state_q == ST_LOCKED);

    AST_LOCK_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (&found)); // R5

    AST_OVF_IMPLIES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> align_err); // R7

    AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(resync) |-> (!locked && !align_err && !overflow)); // R9

endmodule

// File: rtl/tmds_lane_deskew.sv
module tmds_lane_deskew
    import tmds_deskew_pkg::*;
#(
    parameter int LANES = 3,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   resync,
    input  logic [LANES*SYM_W-1:0] lanes_in,
    output logic [LANES*SYM_W-1:0] lanes_out,
    output logic                   aligned,
    output logic                   align_err,
    output logic                   overflow
);

    localparam int AW = $clog2(DEPTH);

    logic [LANES-1:0] found, marker, out_edge, prev_out_ctl;
    logic [AW-1:0]    rd_addr;
    logic             clr_lanes, locked;
    logic [SYM_W-1:0] rd_char [LANES];
    logic [SYM_W-1:0] out_q   [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        deskew_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_lanes),
            .in_char  (lanes_in[g*SYM_W +: SYM_W]),
            .rd_addr  (rd_addr),
            .found_o  (found[g]),
            .marker_o (marker[g]),
            .rd_char  (rd_char[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[g]        <= CODE_IDLE;
                prev_out_ctl[g] <= 1'b1;
            end else begin
                out_q[g]        <= (locked && !resync) ? rd_char[g] : CODE_IDLE;
                prev_out_ctl[g] <= is_ctl_char(out_q[g]);
            end
        end

        assign out_edge[g]                  = prev_out_ctl[g] && !is_ctl_char(out_q[g]);
        assign lanes_out[g*SYM_W +: SYM_W] = out_q[g];

        AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (!locked && !$past(locked)) |-> (out_q[g] == CODE_IDLE)); // R10
    end

    deskew_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .resync    (resync),
        .found     (found),
        .marker    (marker),
        .out_edge  (out_edge),
        .clr_lanes (clr_lanes),
        .rd_addr   (rd_addr),
        .locked    (locked),
        .align_err (align_err),
        .overflow  (overflow)
    );

    assign aligned = locked;

endmodule

// File: tb/tmds_lane_deskew_test.sv
`timescale 1ns/1ps
module tmds_lane_deskew_test;

    localparam logic [9:0] K00 = 10'b1101010100;
    localparam logic [9:0] K01 = 10'b0010101011;
    localparam logic [9:0] K10 = 10'b0101010100;
    localparam logic [9:0] K11 = 10'b1010101011;
    localparam int NC = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resync = 1'b0;
    logic [29:0] lanes_in = {3{K00}};
    logic [29:0] lanes_out;
    logic        aligned, align_err, overflow;

    always #2.5 clk = ~clk;

    tmds_lane_deskew uut (
        .clk(clk), .rst_n(rst_n), .resync(resync), .lanes_in(lanes_in),
        .lanes_out(lanes_out), .aligned(aligned), .align_err(align_err),
        .overflow(overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cl = 6, dl = 24, gap = 6, dl2 = 0;
    int sk[3];
    int ex[3];
    logic [9:0] kc[3];

    function automatic logic [9:0] dat(int ln, int j);
        return 10'((j * 7 + ln * 3 + 5) % 128);
    endfunction

    function automatic logic [9:0] tmpl(int ln, int k);
        int b1, b2;
        b1 = cl + dl;
        b2 = b1 + gap + ex[ln];
        if (k < cl)       return kc[ln];
        if (k < b1)       return dat(ln, k - cl);
        if (k < b2)       return kc[ln];
        if (k < b2 + dl2) return dat(ln, k - b2 + 40);
        return kc[ln];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_resync();
        @(negedge clk);
        resync = 1'b1;
        lanes_in = {3{K00}};
        @(negedge clk);
        resync = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int s0, input int s1, input int s2, input int e2,
                       input int d2, input bit chk, input string tag);
        int smax, bad_al, bad_d;
        logic [31:0] fa, fe;
        do_resync();
        sk[0] = s0; sk[1] = s1; sk[2] = s2;
        ex[0] = 0;  ex[1] = 0;  ex[2] = e2;
        dl2 = d2;
        smax = s0;
        if (s1 > smax) smax = s1;
        if (s2 > smax) smax = s2;
        bad_al = 0; bad_d = 0; fa = 0; fe = 0;
        for (int c = 0; c < NC; c++) begin
            @(negedge clk);
            if (chk && c > 0) begin
                if (aligned !== (c >= cl + smax + 1)) bad_al++;
                for (int i = 0; i < 3; i++) begin
                    logic [9:0] e;
                    e = (c >= cl + smax + 2) ? tmpl(i, c - 2 - smax) : K00;
                    if (lanes_out[i*10 +: 10] !== e) begin
                        if (bad_d == 0) begin
                            fa = 32'(lanes_out[i*10 +: 10]);
                            fe = 32'(e);
                        end
                        bad_d++;
                    end
                end
            end
            for (int i = 0; i < 3; i++) lanes_in[i*10 +: 10] = tmpl(i, c - sk[i]);
        end
        if (chk) begin
            check(bad_al == 0, {tag, " R5 aligned timing"}, 32'(bad_al), 0);
            check(bad_d == 0, {tag, " R5 lane data"}, fa, fe);
            check(align_err == 1'b0, {tag, " R6 no error"}, 32'(align_err), 0);
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lanes_out == {3{K00}}, "R10 reset idle output", lanes_out, {3{K00}});
        check({aligned, align_err, overflow} == 3'b000, "R10 reset status",
              {aligned, align_err, overflow}, 0);
    endtask

    task automatic t_zero_skew();
        kc[0] = K00; kc[1] = K00; kc[2] = K00;
        run(0, 0, 0, 0, 0, 1'b1, "R2 zero skew");
    endtask

    task automatic t_other_codes();
        kc[0] = K01; kc[1] = K10; kc[2] = K11;
        run(3, 0, 7, 0, 0, 1'b1, "R1 mixed codes skew 3/0/7");
        kc[0] = K11; kc[1] = K00; kc[2] = K01;
        run(1, 5, 2, 0, 0, 1'b1, "R1 rotated codes skew 1/5/2");
    endtask

    task automatic t_max_skew();
        kc[0] = K00; kc[1] = K00; kc[2] = K00;
        run(0, 15, 5, 0, 0, 1'b1, "R6 R3 R4 spread 15");
    endtask

    task automatic t_second_burst_ok();
        kc[0] = K00; kc[1] = K10; kc[2] = K00;
        run(2, 1, 0, 0, 10, 1'b1, "R8 two bursts in step");
        check(aligned == 1'b1, "R8 lock kept", 32'(aligned), 1);
    endtask

    task automatic t_slip();
        kc[0] = K00; kc[1] = K00; kc[2] = K00;
        run(0, 0, 0, 1, 10, 1'b0, "R8 slip");
        check(aligned == 1'b0, "R8 slip clears aligned", 32'(aligned), 0);
        check(align_err == 1'b1, "R8 slip sets error", 32'(align_err), 1);
        check(overflow == 1'b0, "R8 slip leaves overflow", 32'(overflow), 0);
        repeat (20) @(negedge clk);
        check(align_err == 1'b1, "R11 error sticky", 32'(align_err), 1);
    endtask

    task automatic t_span_overflow();
        kc[0] = K00; kc[1] = K00; kc[2] = K00;
        run(0, 16, 2, 0, 0, 1'b0, "R7 spread 16");
        check(aligned == 1'b0, "R7 no lock", 32'(aligned), 0);
        check(align_err == 1'b1, "R7 error set", 32'(align_err), 1);
        check(overflow == 1'b1, "R7 overflow set", 32'(overflow), 1);
        check(lanes_out == {3{K00}}, "R10 idle while unaligned", lanes_out, {3{K00}});
        do_resync();
        check({aligned, align_err, overflow} == 3'b000, "R9 resync clears flags",
              {aligned, align_err, overflow}, 0);
        check(overflow == 1'b0, "R11 overflow cleared only by resync", 32'(overflow), 0);
    endtask

    task automatic t_recover();
        kc[0] = K00; kc[1] = K00; kc[2] = K00;
        run(4, 9, 0, 0, 0, 1'b1, "R9 recovery after resync");
    endtask

    task automatic t_resync_locked();
        kc[0] = K00; kc[1] = K00; kc[2] = K00;
        run(1, 1, 1, 0, 0, 1'b1, "R9 pre-resync lock");
        lanes_in = {3{10'h011}};
        @(negedge clk);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        check(aligned == 1'b0, "R9 resync drops lock", 32'(aligned), 0);
        check(lanes_out == {3{K00}}, "R9 R10 idle after resync", lanes_out, {3{K00}});
    endtask

    initial begin
        t_reset();
        t_zero_skew();
        t_other_codes();
        t_max_skew();
        t_second_burst_ok();
        t_slip();
        t_span_overflow();
        t_recover();
        t_resync_locked();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule